// File: doc/BRIEF.md
# Gated Periodic Spike Encoder Array

This block is the input layer of a spiking network. It turns a set of static binary pixel values into regular spike trains. Each channel computes no potential. While its pixel bit is 1, the channel emits a spike once every `PERIOD_TICKS` time steps. While the bit is 0, the channel stays silent. One channel serves each pixel, so a 3×3 black-and-white image uses nine channels. The spike outputs feed the first layer of neurons.

Time is counted in steps marked by `tick_i`. This input is a one-cycle enable pulse in the system clock domain, normally one per millisecond. Pixel levels are sampled only in tick cycles. Each spike output is a register that changes only at a tick. A spike is therefore exactly one time step wide and aligned to the step grid. A pixel that is held at 1 from a silent state fires on the first step. It then fires every `PERIOD_TICKS` steps after that. When the pixel drops to 0, its phase is cleared, so the next activation starts a full period again.

Top module: `spike_train_encoder`

## Requirements
- R1: During and after a synchronous active-high reset, every bit of `spike_o` is 0 and every channel phase is cleared. The first tick at which a pixel is sampled as 1 therefore produces a spike.
- R2: `spike_o` changes only in the clock edge of a cycle in which `tick_i` is 1. Between ticks it holds its value.
- R3: If a channel's pixel is sampled as 0 at a tick, that channel's `spike_o` bit is 0 for the following time step.
- R4: If a channel's pixel is sampled as 1 at a tick, and was 0 at the previous tick (or no tick has occurred since reset), that channel's `spike_o` bit is 1 for the following time step.
- R5: While a pixel stays 1 at every tick, its channel spikes on the 1st, (1+P)th, (1+2P)th ... active tick, where P = `PERIOD_TICKS` (default 50, at least 2). It is silent at all other ticks.
- R6: A spike lasts exactly one time step. A `spike_o` bit that is 1 when a tick occurs becomes 0 at that tick.
- R7: A pixel that is sampled as 0 at one tick and then as 1 again spikes on that first tick back. Its period restarts from there, regardless of the phase it had reached before.
- R8: The channels are independent. Bit k of `spike_o` depends only on bit k of `pixel_i` and on `tick_i`.
- R9: Changes of `pixel_i` between ticks that are undone before the next tick have no effect on `spike_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle time-step enable pulse |
| pixel_i | input | NUM_CH | Level-held binary input, one bit per channel |
| spike_o | output | NUM_CH | Registered spike outputs, one time step wide |

## Verification
A channel phase counter that is stuck, skips a value or is left uncleared shows at the spike outputs. The train then starts late or early after an activation, or the spacing between spikes deviates from P. The error is visible at the first activation tick, or at the latest within P+1 ticks of the fault. A spike register that updates outside tick cycles breaks the step alignment within a single clock. Spike trains on the other channels expose any crosstalk between channels at once, because several pixel images run side by side.

// File: rtl/spk_enc_pkg.sv
package spk_enc_pkg;
  // Default number of channels (one per pixel of a 3x3 image)
  localparam int unsigned SPK_CH_DEFAULT     = 9;
  // Default spike spacing in time steps
  localparam int unsigned SPK_PERIOD_DEFAULT = 50;

  // Counter width needed to hold phases 0 .. period-1
  function automatic int unsigned phase_width(input int unsigned period);
    return (period > 2) ? $clog2(period) : 1;
  endfunction
endpackage

// File: rtl/enc_phase_counter.sv
module enc_phase_counter #(
  parameter int unsigned PERIOD_TICKS = spk_enc_pkg::SPK_PERIOD_DEFAULT,
  localparam int unsigned CNT_W = spk_enc_pkg::phase_width(PERIOD_TICKS)
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic adv_i,     // tick with pixel active
  input  logic clr_i,     // tick with pixel inactive
  output logic at_zero_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);

  logic [CNT_W-1:0] phase_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) begin
      phase_q <= '0;
    end else if (adv_i) begin
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  end

  assign at_zero_o = (phase_q == '0);
endmodule

// File: rtl/enc_spike_reg.sv
module enc_spike_reg (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic fire_i,
  output logic spike_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      spike_o <= 1'b0;
    end else if (tick_i) begin
      spike_o <= fire_i;
    end
  end
endmodule

// File: rtl/spike_train_encoder.sv
module spike_train_encoder #(
  parameter int unsigned NUM_CH       = spk_enc_pkg::SPK_CH_DEFAULT,
  parameter int unsigned PERIOD_TICKS = spk_enc_pkg::SPK_PERIOD_DEFAULT
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tick_i,
  input  logic [NUM_CH-1:0] pixel_i,
  output logic [NUM_CH-1:0] spike_o
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic at_zero;
    logic adv;
    logic clr;

    assign adv = tick_i &  pixel_i[ch];
    assign clr = tick_i & ~pixel_i[ch];

    enc_phase_counter #(.PERIOD_TICKS(PERIOD_TICKS)) u_phase (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .adv_i     (adv),
      .clr_i     (clr),
      .at_zero_o (at_zero)
    );

    enc_spike_reg u_spk (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .tick_i  (tick_i),
      .fire_i  (pixel_i[ch] & at_zero),
      .spike_o (spike_o[ch])
    );
  end
endmodule

// File: rtl/spike_train_encoder_chk.sv
module spike_train_encoder_chk #(
  parameter int unsigned NUM_CH       = spk_enc_pkg::SPK_CH_DEFAULT,
  parameter int unsigned PERIOD_TICKS = spk_enc_pkg::SPK_PERIOD_DEFAULT
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              tick_i,
  input logic [NUM_CH-1:0] pixel_i,
  input logic [NUM_CH-1:0] spike_o
);
  logic [NUM_CH-1:0] seen_q;  // pixel level at the previous tick

  always_ff @(posedge clk_i) begin
    if (rst_i) seen_q <= '0;
    else if (tick_i) seen_q <= pixel_i;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    rst_i |=> (spike_o == '0));

  // R2
  step_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick_i |=> $stable(spike_o));

  // R3
  idle_silent_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_i |=> ((spike_o & ~$past(pixel_i)) == '0));

  // R6
  one_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_i |=> (($past(spike_o) & spike_o) == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R4
    first_fire_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (tick_i && pixel_i[g] && !seen_q[g]) |=> spike_o[g]);
  end
endmodule

bind spike_train_encoder spike_train_encoder_chk #(
  .NUM_CH       (NUM_CH),
  .PERIOD_TICKS (PERIOD_TICKS)
) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .tick_i  (tick_i),
  .pixel_i (pixel_i),
  .spike_o (spike_o)
);

// File: tb/spike_train_encoder_tb.sv
module spike_train_encoder_tb;
  localparam int unsigned NCH = 9;
  localparam int unsigned P   = 50;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           tick = 1'b0;
  logic [NCH-1:0] pixel = '0;
  logic [NCH-1:0] spike;

  int checks = 0;
  int fails  = 0;
  int ph [NCH];
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  spike_train_encoder #(.NUM_CH(NCH), .PERIOD_TICKS(P)) u_dut (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .pixel_i(pixel), .spike_o(spike)
  );

  task automatic check_vec(input string req, input logic [NCH-1:0] exp);
    checks++;
    if (spike !== exp) begin
      fails++;
      $display("FAIL %s: spike_o=%b expected %b", req, spike, exp);
    end
  endtask

  // One time step: expected value from the requirements, then pulse tick.
  task automatic do_tick(input string req);
    logic [NCH-1:0] exp;
    for (int c = 0; c < NCH; c++) begin
      if (pixel[c]) begin
        exp[c] = (ph[c] == 0);
        ph[c]  = (ph[c] + 1) % P;
      end else begin
        exp[c] = 1'b0;
        ph[c]  = 0;
      end
    end
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    check_vec(req, exp);
    @(negedge clk);
    check_vec("R2 hold between ticks", exp);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    pixel = '1;
    repeat (3) @(negedge clk);
    check_vec("R1 reset", '0);
    rst = 1'b0;
    for (int c = 0; c < NCH; c++) ph[c] = 0;
    do_tick("R1 first tick after reset fires");
  endtask

  task automatic t_full_image();
    pixel = '1;
    for (int k = 0; k < 2 * P + 2; k++) do_tick("R5 periodic train");
  endtask

  task automatic t_pattern();
    pixel = '0;
    do_tick("R3 all inactive");
    pixel = 9'b010_111_010;
    for (int k = 0; k < P + 3; k++) do_tick("R8 cross pattern");
    pixel = 9'b101_000_101;
    for (int k = 0; k < 4; k++) do_tick("R4 new pixels fire, old go silent");
  endtask

  task automatic t_restart();
    pixel = '1;
    for (int k = 0; k < 7; k++) do_tick("R5 mid-period");
    pixel = 9'b000_000_111;
    do_tick("R3 deactivate");
    pixel = '1;
    for (int k = 0; k < 4; k++) do_tick("R7 restart full period");
  endtask

  task automatic t_glitch();
    pixel = 9'b111_000_000;
    do_tick("R9 setup");
    do_tick("R9 setup");
    @(negedge clk) pixel = 9'b000_111_000;
    @(negedge clk);
    check_vec("R9 no effect between ticks", 9'b000_000_000);
    pixel = 9'b111_000_000;
    for (int k = 0; k < P; k++) do_tick("R9 train unaffected by glitch");
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) ph[c] = 0;
    t_reset();
    t_full_image();
    t_pattern();
    t_restart();
    t_glitch();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule